// File: doc/BRIEF.md
# Parallel-Load Serial-Out Shift Register

This block is a chain of storage stages that either captures a parallel word or moves serial data one place toward a single output. A controller drives an active-low load control low to capture the word. It then holds the control high and produces edges on a shift clock to read the captured bits out one at a time, last stage first. A second input, the clock inhibit, is ORed with the shift clock. Holding it high blocks shifting. Because the two inputs are symmetric, a rising edge on either one shifts while the other is held low. Two outputs are provided: the true value of the last stage and its complement.

The block lives in a single system clock domain. The shift clock and the inhibit are level inputs that are sampled on that clock. Each must stay at a level for at least one system clock cycle, and the two should not change in the same cycle.

While the load control is low, the true output follows the parallel input of the last stage combinationally, with no clock edge needed. The stages themselves are refreshed from the parallel inputs on every system clock edge for as long as the control stays low.

Instances can be cascaded by feeding the true output of one into the serial input of the next and sharing the shift clock. The result behaves as one longer chain. A parameter sets the stage count. A second parameter chooses whether the stages take a synchronous reset or start with no defined value.

Top module: `piso_shreg`

## Requirements
- R1: A synchronous reset (active high) clears every stage to 0. With the load control high after reset, q_out is 0 and q_out_n is 1.
- R2: While load_n is 0, q_out equals par_in[STAGES-1] combinationally, without any clock edge, and follows changes on that input at once.
- R3: At every system clock edge where load_n is 0, stage i takes par_in[i]. Index 0 is the first stage and index STAGES-1 is the last stage. After load_n returns to 1, successive shifts present par_in[STAGES-1], par_in[STAGES-2], down to par_in[0] on q_out.
- R4: With load_n at 1, a shift happens at a system clock edge where the gate (shift_clk OR clk_inhibit) is sampled 1 and was sampled 0 at the previous edge. Stage 0 takes ser_in, stage i takes stage i-1, and the old last-stage value is dropped. The new last stage shows on q_out right after that edge.
- R5: With load_n at 1 and no rising gate, every stage holds its value. This includes the case where shift_clk toggles while clk_inhibit is held at 1.
- R6: A rising edge of clk_inhibit while shift_clk is held at 0 shifts exactly as a rising edge of shift_clk does.
- R7: The load control overrides shifting. A gate rise while load_n is 0 causes no shift. If the gate is already 1 when load_n returns to 1, no shift occurs until the gate falls and rises again.
- R8: q_out_n is always the inverse of q_out.
- R9: When q_out of one instance drives ser_in of a second instance and the two share the load control and the gate, the pair behaves as one chain whose length is the sum of their stage counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all stages update on its rising edge |
| rst | input | 1 | Synchronous reset, active high (used when RESET_EN is 1) |
| load_n | input | 1 | Active-low load control; 0 captures par_in, 1 allows shifting |
| shift_clk | input | 1 | Shift clock level, sampled by clk |
| clk_inhibit | input | 1 | Inhibit level; ORed with shift_clk to form the gate |
| ser_in | input | 1 | Serial data entering stage 0 on a shift |
| par_in | input | STAGES | Parallel word; bit i loads stage i |
| q_out | output | 1 | True serial output from the last stage |
| q_out_n | output | 1 | Complement of q_out |

## Verification
The bench builds one instance with the default STAGES=8 and reset enabled. A second instance, built with STAGES=5, takes the first one's output as its serial input. The odd, non-power-of-two length exercises the slicing at the chain's edges at a size unlike the default. The 13-stage cascade shows that the last-stage value leaves one instance and enters the next at the same edge, with no bit lost or repeated. Random cycles mix loads, gate rises from either input and holds. Directed sequences cover the load bypass, inhibit masking, a gate that is already high on load release, and a full cascaded readout.

// File: rtl/piso_pkg.sv
package piso_pkg;

   typedef enum logic [1:0] {
      OP_HOLD  = 2'd0,
      OP_LOAD  = 2'd1,
      OP_SHIFT = 2'd2
   } piso_op_e;

   // The load level wins over any gate rise; a rise shifts only while loading is off.
   function automatic piso_op_e piso_decode(input logic load_n, input logic fire);
      if (!load_n)
         return OP_LOAD;
      else if (fire)
         return OP_SHIFT;
      else
         return OP_HOLD;
   endfunction

endpackage

// File: rtl/piso_gate_edge.sv
// Forms the gate from the shift clock and the inhibit, and flags its rising edge.
module piso_gate_edge #(
   parameter bit RESET_EN = 1'b1
) (
   input  logic clk,
   input  logic rst,
   input  logic shift_clk,
   input  logic clk_inhibit,
   output logic fire
);
   logic gate;
   logic gate_prev;

   assign gate = shift_clk | clk_inhibit;

   generate
      if (RESET_EN) begin : g_rst
         // Reset to 1 so that a gate already high at reset release does not count as a rise.
         always_ff @(posedge clk) begin
            if (rst) gate_prev <= 1'b1;
            else     gate_prev <= gate;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            gate_prev <= gate;
         end
      end
   endgenerate

   assign fire = gate & ~gate_prev;

endmodule

// File: rtl/piso_stage_chain.sv
// The storage stages: index 0 is the first stage, index STAGES-1 drives the output.
module piso_stage_chain
   import piso_pkg::*;
#(
   parameter int unsigned STAGES   = 8,
   parameter bit          RESET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  piso_op_e          op,
   input  logic              ser_in,
   input  logic [STAGES-1:0] par_in,
   output logic [STAGES-1:0] stage_q
);
   localparam int unsigned LAST = STAGES - 1;

   logic [STAGES-1:0] chain_in;
   logic [STAGES-1:0] stage_d;

   assign chain_in = {stage_q[LAST-1:0], ser_in};

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_comb begin
            unique case (op)
               OP_LOAD:  stage_d[i] = par_in[i];
               OP_SHIFT: stage_d[i] = chain_in[i];
               default:  stage_d[i] = stage_q[i];
            endcase
         end
      end

      if (RESET_EN) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst) stage_q <= '0;
            else     stage_q <= stage_d;
         end
      end else begin : g_norst
         always_ff @(posedge clk) begin
            stage_q <= stage_d;
         end
      end
   endgenerate

endmodule

// File: rtl/piso_out_drive.sv
// Output selection: during a load the last parallel bit bypasses the registers.
module piso_out_drive (
   input  logic load_n,
   input  logic last_stage,
   input  logic par_last,
   output logic q_out,
   output logic q_out_n
);
   logic q_sel;

   always_comb begin
      if (load_n) q_sel = last_stage;
      else        q_sel = par_last;
   end

   assign q_out   = q_sel;
   assign q_out_n = ~q_sel;

endmodule

// File: rtl/piso_shreg.sv
module piso_shreg
   import piso_pkg::*;
#(
   parameter int unsigned STAGES   = 8,
   parameter bit          RESET_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_n,
   input  logic              shift_clk,
   input  logic              clk_inhibit,
   input  logic              ser_in,
   input  logic [STAGES-1:0] par_in,
   output logic              q_out,
   output logic              q_out_n
);
   localparam int unsigned LAST = STAGES - 1;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("piso_shreg: STAGES must be at least 2");
      end
   endgenerate

   logic              fire;
   piso_op_e          op;
   logic [STAGES-1:0] stage_q;

   piso_gate_edge #(
      .RESET_EN (RESET_EN)
   ) u_edge (
      .clk         (clk),
      .rst         (rst),
      .shift_clk   (shift_clk),
      .clk_inhibit (clk_inhibit),
      .fire        (fire)
   );

   assign op = piso_decode(load_n, fire);

   piso_stage_chain #(
      .STAGES   (STAGES),
      .RESET_EN (RESET_EN)
   ) u_chain (
      .clk     (clk),
      .rst     (rst),
      .op      (op),
      .ser_in  (ser_in),
      .par_in  (par_in),
      .stage_q (stage_q)
   );

   piso_out_drive u_out (
      .load_n     (load_n),
      .last_stage (stage_q[LAST]),
      .par_last   (par_in[LAST]),
      .q_out      (q_out),
      .q_out_n    (q_out_n)
   );

endmodule

// File: rtl/piso_shreg_chk.sv
module piso_shreg_chk #(
   parameter int unsigned STAGES = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              load_n,
   input logic              shift_clk,
   input logic              clk_inhibit,
   input logic              ser_in,
   input logic [STAGES-1:0] par_in,
   input logic [STAGES-1:0] stage_q
);
   logic armed;
   logic gate;
   logic gate_prev;
   logic rise;

   assign gate = shift_clk | clk_inhibit;
   assign rise = gate & ~gate_prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         armed     <= 1'b0;
         gate_prev <= 1'b1;
      end else begin
         armed     <= 1'b1;
         gate_prev <= gate;
      end
   end

   // R3: a low load control captures the parallel word by the next edge
   assert_load_capture_R3: assert property (@(posedge clk) disable iff (rst)
      (armed && !load_n) |=> (stage_q == $past(par_in)));

   // R4: a gate rise with loading off moves every stage one place
   assert_shift_step_R4: assert property (@(posedge clk) disable iff (rst)
      (armed && load_n && rise) |=>
         (stage_q == {$past(stage_q[STAGES-2:0]), $past(ser_in)}));

   // R5: no rise and no load leaves the contents untouched
   assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (armed && load_n && !rise) |=> $stable(stage_q));

   // R7: releasing the load with the gate already high does not shift
   assert_no_release_shift_R7: assert property (@(posedge clk) disable iff (rst)
      (armed && load_n && !$past(load_n) && gate && $past(gate)) |=> $stable(stage_q));

endmodule

bind piso_shreg piso_shreg_chk #(.STAGES(STAGES)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .load_n      (load_n),
   .shift_clk   (shift_clk),
   .clk_inhibit (clk_inhibit),
   .ser_in      (ser_in),
   .par_in      (par_in),
   .stage_q     (stage_q)
);

// File: tb/piso_shreg_bench.sv
module piso_shreg_bench;

   logic       clk = 1'b0;
   logic       rst;
   logic       load_n;
   logic       sclk;
   logic       inh;
   logic       ser;
   logic [7:0] par_a;
   logic [4:0] par_b;
   logic       q_a, qn_a, q_b, qn_b;

   always #5 clk = ~clk;

   piso_shreg #(.STAGES(8)) u_piso_shreg (
      .clk (clk), .rst (rst), .load_n (load_n), .shift_clk (sclk),
      .clk_inhibit (inh), .ser_in (ser), .par_in (par_a),
      .q_out (q_a), .q_out_n (qn_a)
   );

   piso_shreg #(.STAGES(5)) u_piso_shreg_tail (
      .clk (clk), .rst (rst), .load_n (load_n), .shift_clk (sclk),
      .clk_inhibit (inh), .ser_in (q_a), .par_in (par_b),
      .q_out (q_b), .q_out_n (qn_b)
   );

   // Reference model of both chains
   logic [7:0] ma;
   logic [4:0] mb;
   logic       mprev;
   int         checks   = 0;
   int         failures = 0;
   bit         done     = 1'b0;

   task automatic chk(string tag, logic got, logic exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic logic exp_out(logic ld, logic last_m, logic last_p);
      return ld ? last_m : last_p;
   endfunction

   task automatic check_all(string tag);
      logic ea, eb;
      ea = exp_out(load_n, ma[7], par_a[7]);
      eb = exp_out(load_n, mb[4], par_b[4]);
      chk(tag, q_a, ea);
      chk("R8 complement head", qn_a, ~ea);
      chk({tag, " tail R9"}, q_b, eb);
      chk("R8 complement tail", qn_b, ~eb);
   endtask

   // One system clock: update the model at the edge, compare at the falling edge
   task automatic tick();
      logic  gate, rise;
      string tag;
      @(posedge clk);
      gate = sclk | inh;
      rise = gate & ~mprev;
      if (rst) begin
         ma = '0; mb = '0; mprev = 1'b1; tag = "R1 reset";
      end else begin
         mprev = gate;
         if (!load_n) begin
            ma = par_a; mb = par_b; tag = "R3 load";
         end else if (rise) begin
            mb = {mb[3:0], ma[7]}; ma = {ma[6:0], ser}; tag = "R4 shift";
         end else begin
            tag = "R5 hold";
         end
      end
      @(negedge clk);
      if (!rst) check_all(tag);
   endtask

   task automatic do_shift(logic s);
      ser = s; sclk = 1'b0; tick();
      sclk = 1'b1; tick();
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [7:0]  pat;
      logic [15:0] sseq;
      logic [28:0] stream;
      int unsigned r;

      rst = 1'b1; load_n = 1'b1; sclk = 1'b0; inh = 1'b0; ser = 1'b0;
      par_a = '0; par_b = '0; ma = '0; mb = '0; mprev = 1'b1;
      r = $urandom(32'h1A2B);
      @(negedge clk);
      repeat (3) tick();
      rst = 1'b0;
      tick();
      chk("R1 reset q_out", q_a, 1'b0);
      chk("R1 reset q_out_n", qn_a, 1'b1);
      chk("R1 reset tail q_out", q_b, 1'b0);

      // R2: combinational bypass while loading, no clock edge between checks
      load_n = 1'b0; par_a = 8'hA5; par_b = 5'h0A;
      #1 chk("R2 bypass high", q_a, 1'b1);
      chk("R2 bypass complement", qn_a, 1'b0);
      par_a = 8'h25;
      #1 chk("R2 bypass follows", q_a, 1'b0);
      chk("R2 tail bypass", q_b, 1'b0);
      @(negedge clk);

      // R3: capture then serial readout, last stage first
      pat = 8'hC6; par_a = pat; tick();
      load_n = 1'b1; tick();
      for (int k = 0; k < 8; k++) begin
         chk("R3 readout order", q_a, pat[7-k]);
         do_shift(1'b0);
      end

      // R5: inhibit high masks shift_clk toggles
      pat = 8'h96; load_n = 1'b0; par_a = pat; sclk = 1'b0; tick();
      load_n = 1'b1; tick();
      inh = 1'b1; tick();
      chk("R6 inhibit rise shifts", q_a, pat[6]);
      for (int k = 0; k < 6; k++) begin
         sclk = ~sclk; tick();
         chk("R5 inhibit blocks shift", q_a, pat[6]);
      end
      sclk = 1'b0; tick();
      inh = 1'b0; tick();
      chk("R5 gate fall holds", q_a, pat[6]);

      // R6: inhibit used as the clock while shift_clk stays low
      inh = 1'b1; tick();
      chk("R6 second inhibit rise", q_a, pat[5]);
      inh = 1'b0; tick();
      inh = 1'b1; tick();
      chk("R6 third inhibit rise", q_a, pat[4]);
      inh = 1'b0; tick();

      // R7: load overrides a rise; release with the gate high does not shift
      pat = 8'hB4; load_n = 1'b0; par_a = pat; tick();
      sclk = 1'b1; tick();
      chk("R7 rise during load", q_a, pat[7]);
      load_n = 1'b1; tick();
      chk("R7 no shift on release", q_a, pat[7]);
      tick();
      chk("R7 still held", q_a, pat[7]);
      sclk = 1'b0; tick();
      sclk = 1'b1; tick();
      chk("R7 later rise shifts", q_a, pat[6]);

      // R9: 13-stage cascade readout
      par_a = 8'h4D; par_b = 5'h13; sseq = 16'hA35C;
      load_n = 1'b0; tick();
      load_n = 1'b1; tick();
      stream = {par_b, par_a, sseq};
      for (int k = 0; k < 16; k++) begin
         chk("R9 cascade order", q_b, stream[28-k]);
         do_shift(sseq[15-k]);
      end

      // Random mix of load, shift and hold
      for (int n = 0; n < 4000; n++) begin
         r = $urandom;
         load_n = (r[2:0] != 3'd0);
         case (r[4:3])
            2'd0:    sclk = ~sclk;
            2'd1:    inh  = ~inh;
            default: ;
         endcase
         ser   = r[5];
         par_a = 8'($urandom);
         par_b = 5'($urandom);
         tick();
      end

      finish_run();
   end

endmodule